// File: doc/BRIEF.md
# Keyed Plug-and-Play Configuration Port

This block sits on a host I/O bus and claims a two-byte window. The lower byte is an index port and the byte above it is a data port. Software writes a register number to the index port and then reads or writes that register through the data port. At reset the window is sealed. It opens only after the host writes a fixed four-byte key to the index port. The last byte of the key depends on which of two base addresses the block is built for.

Once the window is open, a small global space is visible. It holds a control register that closes the window again and a selector that picks one logical device. The selector routes the bank registers, at index 0x30 and above, to one of seven device banks. Each bank holds an activate bit, two 16-bit I/O base addresses and an IRQ number. The bank contents drive flat output buses. Downstream functions such as serial ports, the keyboard controller and GPIO read these buses for their enable, base and IRQ settings.

Reads are combinational: `io_rdata_o` is valid in the same cycle that `io_rd_i` is high on a decoded address. Writes take effect at the next rising clock edge.

Top module: `cfg_port`

## Requirements
- R1: After reset the window is locked. Every `dev_en_o` bit is 0. All base and IRQ outputs are 0. The index register and the device selector are 0.
- R2: Writing 0x87, 0x01, 0x55 and a last byte to the index port (BASE_ADDR), in that order, unlocks the window. The last byte is 0x55 when BASE_ADDR is 0x2E and 0xAA otherwise. While unlocked, index-port writes set the index register and index-port reads return it.
- R3: A write of a wrong byte during the key sequence restarts matching. If that wrong byte is 0x87, it is counted as the first key byte.
- R4: While locked, data-port writes and index-port writes change no register. Reads of either port return 0xFF.
- R5: Writing 0x02 through the data port while the index is 0x02 locks the window. Any other value written at index 0x02 leaves it unlocked. Index 0x02 reads as 0x00.
- R6: Index 0x07 is the device selector and reads back the last value written. Values 0x01, 0x02, 0x04, 0x05, 0x06, 0x07 and 0x0A select bank slots 0 to 6 of the output buses, in that order. Any other value selects no bank: bank-register writes are then ignored and bank-register reads return 0xFF.
- R7: Bit 0 at index 0x30 is the selected bank's activate bit. It drives that slot's `dev_en_o` bit and reads back as {7'b0, bit}.
- R8: Index 0x60 holds the high byte and 0x61 the low byte of the first base. Index 0x62 and 0x63 hold the second base in the same order. Both bases read back and appear on `dev_base0_o` and `dev_base1_o`, slot k at bits [16k+15:16k].
- R9: Written base bytes are ANDed with a per-slot mask, applied to both bases. The masks are 0x0FF8 for slots 0, 1, 5 and 6, 0x0FF0 for slot 2, 0x0FFF for slot 3, and 0x0000 for slot 4.
- R10: Index 0x70 holds an 8-bit IRQ number that reads back and appears on `dev_irq_o`, slot k at bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | Host I/O address |
| io_wr_i | input | 1 | Host write strobe |
| io_rd_i | input | 1 | Host read strobe |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Read data; 0xFF when not decoded |
| dev_en_o | output | NUM_DEV | Per-slot activate bits |
| dev_base0_o | output | NUM_DEV*16 | First I/O base per slot |
| dev_base1_o | output | NUM_DEV*16 | Second I/O base per slot |
| dev_irq_o | output | NUM_DEV*8 | IRQ number per slot |

## Verification
A key matcher stuck in the wrong stage shows up on the next port read. The window either stays sealed, with reads of 0xFF, after a valid key, or it opens early after a broken key. A selector that decodes to the wrong slot moves a write onto a neighbouring slot of the output buses. That error is visible one edge after the write, and again on read-back, as a value masked with the wrong alignment. A lost exit or a lost locked-state guard shows on the very next read, as a value other than 0xFF.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int NUM_DEV = 7;
  localparam int BASE_W  = 16;

  localparam logic [7:0] IDX_CTRL = 8'h02;
  localparam logic [7:0] IDX_SEL  = 8'h07;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] IDX_B0H  = 8'h60;
  localparam logic [7:0] IDX_B0L  = 8'h61;
  localparam logic [7:0] IDX_B1H  = 8'h62;
  localparam logic [7:0] IDX_B1L  = 8'h63;
  localparam logic [7:0] IDX_IRQ  = 8'h70;
  localparam logic [7:0] EXIT_VAL = 8'h02;

  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;

  function automatic logic [7:0] slot_ldn(input int k);
    case (k)
      0: slot_ldn = 8'h01;
      1: slot_ldn = 8'h02;
      2: slot_ldn = 8'h04;
      3: slot_ldn = 8'h05;
      4: slot_ldn = 8'h06;
      5: slot_ldn = 8'h07;
      default: slot_ldn = 8'h0A;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] slot_mask(input int k);
    case (k)
      2: slot_mask = 16'h0FF0;
      3: slot_mask = 16'h0FFF;
      4: slot_mask = 16'h0000;
      default: slot_mask = 16'h0FF8;
    endcase
  endfunction
endpackage

// File: rtl/key_unlock.sv
module key_unlock #(
  parameter logic [7:0] KEY_LAST = 8'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  input  logic       lock_i,
  output logic       unlocked_o
);
  import cfgport_pkg::*;

  logic [1:0] stage_q;
  logic       unlocked_q;
  logic [7:0] expect_b;

  always_comb begin
    case (stage_q)
      2'd0: expect_b = KEY_B0;
      2'd1: expect_b = KEY_B1;
      2'd2: expect_b = KEY_B2;
      default: expect_b = KEY_LAST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q    <= '0;
      unlocked_q <= 1'b0;
    end else if (lock_i) begin
      stage_q    <= '0;
      unlocked_q <= 1'b0;
    end else if (key_wr_i && !unlocked_q) begin
      if (key_i == expect_b) begin
        if (stage_q == 2'd3) begin
          stage_q    <= '0;
          unlocked_q <= 1'b1;
        end else begin
          stage_q <= stage_q + 2'd1;
        end
      end else begin
        // a stray first key byte restarts the match at stage one
        stage_q <= (key_i == KEY_B0) ? 2'd1 : 2'd0;
      end
    end
  end

  assign unlocked_o = unlocked_q;

  AST_UNLOCK_ON_LAST_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_q) |-> ($past(key_wr_i) && $past(key_i) == KEY_LAST)); // R2
  AST_STAGE_IDLE_WHEN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_q |-> stage_q == 2'd0); // R3
endmodule

// File: rtl/dev_bank.sv
module dev_bank #(
  parameter logic [15:0] MASK = 16'h0FF8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic        act_o,
  output logic [15:0] base0_o,
  output logic [15:0] base1_o,
  output logic [7:0]  irq_o,
  output logic [7:0]  rdata_o
);
  import cfgport_pkg::*;

  logic        act_q;
  logic [15:0] base0_q, base1_q;
  logic [7:0]  irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      base0_q <= '0;
      base1_q <= '0;
      irq_q   <= '0;
    end else if (wr_i) begin
      case (idx_i)
        IDX_ACT: act_q          <= wdata_i[0];
        IDX_B0H: base0_q[15:8]  <= wdata_i & MASK[15:8];
        IDX_B0L: base0_q[7:0]   <= wdata_i & MASK[7:0];
        IDX_B1H: base1_q[15:8]  <= wdata_i & MASK[15:8];
        IDX_B1L: base1_q[7:0]   <= wdata_i & MASK[7:0];
        IDX_IRQ: irq_q          <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IDX_ACT: rdata_o = {7'b0, act_q};
      IDX_B0H: rdata_o = base0_q[15:8];
      IDX_B0L: rdata_o = base0_q[7:0];
      IDX_B1H: rdata_o = base1_q[15:8];
      IDX_B1L: rdata_o = base1_q[7:0];
      IDX_IRQ: rdata_o = irq_q;
      default: rdata_o = 8'h00;
    endcase
  end

  assign act_o   = act_q;
  assign base0_o = base0_q;
  assign base1_o = base1_q;
  assign irq_o   = irq_q;

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable({act_q, base0_q, base1_q, irq_q})); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((base0_q | base1_q) & ~MASK) == 16'h0000); // R9
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfgport_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h002E
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         io_addr_i,
  input  logic                      io_wr_i,
  input  logic                      io_rd_i,
  input  logic [7:0]                io_wdata_i,
  output logic [7:0]                io_rdata_o,
  output logic [NUM_DEV-1:0]        dev_en_o,
  output logic [NUM_DEV*BASE_W-1:0] dev_base0_o,
  output logic [NUM_DEV*BASE_W-1:0] dev_base1_o,
  output logic [NUM_DEV*8-1:0]      dev_irq_o
);
  localparam logic [7:0]        KEY_LAST = (BASE_ADDR == 16'h002E) ? 8'h55 : 8'hAA;
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_ADDR + 16'd1);

  logic       hit_idx, hit_dat, unlocked;
  logic       lock_req, key_wr, bank_wr;
  logic [7:0] index_q, sel_q;
  logic [NUM_DEV-1:0] bank_sel;
  logic [7:0] bank_rd [NUM_DEV];
  logic [7:0] bank_mux;

  assign hit_idx = (io_addr_i == IDX_PORT);
  assign hit_dat = (io_addr_i == DAT_PORT);
  assign key_wr  = io_wr_i && hit_idx && !unlocked;
  assign lock_req = unlocked && io_wr_i && hit_dat &&
                    (index_q == IDX_CTRL) && (io_wdata_i == EXIT_VAL);
  assign bank_wr = unlocked && io_wr_i && hit_dat && (index_q >= IDX_ACT);

  key_unlock #(.KEY_LAST(KEY_LAST)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_i      (io_wdata_i),
    .lock_i     (lock_req),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      sel_q   <= '0;
    end else if (unlocked && io_wr_i) begin
      if (hit_idx) index_q <= io_wdata_i;
      else if (hit_dat && index_q == IDX_SEL) sel_q <= io_wdata_i;
    end
  end

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_bank
    assign bank_sel[k] = (sel_q == slot_ldn(k));
    dev_bank #(.MASK(slot_mask(k))) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bank_wr && bank_sel[k]),
      .idx_i   (index_q),
      .wdata_i (io_wdata_i),
      .act_o   (dev_en_o[k]),
      .base0_o (dev_base0_o[k*BASE_W +: BASE_W]),
      .base1_o (dev_base1_o[k*BASE_W +: BASE_W]),
      .irq_o   (dev_irq_o[k*8 +: 8]),
      .rdata_o (bank_rd[k])
    );
  end

  always_comb begin
    bank_mux = 8'hFF;
    for (int k = 0; k < NUM_DEV; k++)
      if (bank_sel[k]) bank_mux = bank_rd[k];
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_rd_i && unlocked) begin
      if (hit_idx) io_rdata_o = index_q;
      else if (hit_dat) begin
        if (index_q == IDX_SEL)      io_rdata_o = sel_q;
        else if (index_q >= IDX_ACT) io_rdata_o = bank_mux;
        else                         io_rdata_o = 8'h00;
      end
    end
  end

  AST_LOCKED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && io_rd_i && (hit_idx || hit_dat)) |-> io_rdata_o == 8'hFF); // R4
  AST_LOCKED_INDEX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(index_q) && $stable(sel_q)); // R4
  AST_EXIT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_req |=> !unlocked); // R5
  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_sel)); // R6
endmodule

// File: tb/cfg_port_tb.sv
module cfg_port_tb_top;
  import cfgport_pkg::*;

  typedef struct packed {
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  d;
    logic [3:0]  rq;
  } vec_t;

  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;
  localparam int NV = 53;
  // rq field holds the requirement number of each read
  localparam vec_t VECS [NV] = '{
    '{1'b1, DP, 8'hFF, 4'd4}, '{1'b0, DP, 8'h12, 4'd4}, '{1'b1, IP, 8'hFF, 4'd4},   // R4 locked
    '{1'b0, IP, 8'h87, 4'd2}, '{1'b0, IP, 8'h01, 4'd2}, '{1'b0, IP, 8'h55, 4'd2},
    '{1'b0, IP, 8'h55, 4'd2}, '{1'b1, IP, 8'h00, 4'd2},                             // R2 key
    '{1'b0, IP, 8'h07, 4'd6}, '{1'b0, DP, 8'h01, 4'd6}, '{1'b1, DP, 8'h01, 4'd6},   // R6
    '{1'b0, IP, 8'h60, 4'd9}, '{1'b0, DP, 8'hFF, 4'd9}, '{1'b1, DP, 8'h0F, 4'd9},   // R9
    '{1'b0, IP, 8'h61, 4'd9}, '{1'b0, DP, 8'hFF, 4'd9}, '{1'b1, DP, 8'hF8, 4'd9},
    '{1'b0, IP, 8'h30, 4'd7}, '{1'b0, DP, 8'h01, 4'd7}, '{1'b1, DP, 8'h01, 4'd7},   // R7
    '{1'b0, IP, 8'h70, 4'd10}, '{1'b0, DP, 8'h04, 4'd10}, '{1'b1, DP, 8'h04, 4'd10}, // R10
    '{1'b0, IP, 8'h07, 4'd9}, '{1'b0, DP, 8'h04, 4'd9}, '{1'b0, IP, 8'h61, 4'd9},
    '{1'b0, DP, 8'h3F, 4'd9}, '{1'b1, DP, 8'h30, 4'd9},
    '{1'b0, IP, 8'h62, 4'd8}, '{1'b0, DP, 8'h0A, 4'd8}, '{1'b1, DP, 8'h0A, 4'd8},   // R8
    '{1'b0, IP, 8'h07, 4'd9}, '{1'b0, DP, 8'h05, 4'd9}, '{1'b0, IP, 8'h63, 4'd9},
    '{1'b0, DP, 8'h67, 4'd9}, '{1'b1, DP, 8'h67, 4'd9},
    '{1'b0, IP, 8'h07, 4'd6}, '{1'b0, DP, 8'h03, 4'd6}, '{1'b1, DP, 8'h03, 4'd6},
    '{1'b0, IP, 8'h30, 4'd6}, '{1'b0, DP, 8'h01, 4'd6}, '{1'b1, DP, 8'hFF, 4'd6},
    '{1'b0, IP, 8'h07, 4'd9}, '{1'b0, DP, 8'h0A, 4'd9}, '{1'b0, IP, 8'h60, 4'd9},
    '{1'b0, DP, 8'h12, 4'd9}, '{1'b1, DP, 8'h02, 4'd9},
    '{1'b0, IP, 8'h02, 4'd5}, '{1'b0, DP, 8'h01, 4'd5}, '{1'b1, IP, 8'h02, 4'd5},   // R5
    '{1'b0, DP, 8'h02, 4'd5}, '{1'b1, DP, 8'hFF, 4'd5}, '{1'b1, IP, 8'hFF, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_a, rdata_b;
  logic [NUM_DEV-1:0]        en_a, en_b;
  logic [NUM_DEV*BASE_W-1:0] b0_a, b1_a, b0_b, b1_b;
  logic [NUM_DEV*8-1:0]      irq_a, irq_b;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata_a), .dev_en_o(en_a),
    .dev_base0_o(b0_a), .dev_base1_o(b1_a), .dev_irq_o(irq_a)
  );

  cfg_port #(.BASE_ADDR(16'h004E)) dut_4e_i (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata_b), .dev_en_o(en_b),
    .dev_base0_o(b0_b), .dev_base1_o(b1_b), .dev_irq_o(irq_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd = 1'b1; wr = 1'b0;
    #5;
    check(req, (a[7:4] == 4'h4) ? rdata_b : rdata_a, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", en_a, '0);
    check("R1", {b0_a, b1_a, irq_a} == '0, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) bus_rd(VECS[i].addr, $sformatf("R%0d", VECS[i].rq), VECS[i].d);
      else            bus_wr(VECS[i].addr, VECS[i].d);
    end

    // R7 R6: only slot 0 active; write while no bank selected had no effect
    check("R7", en_a, 7'b0000001);
    check("R8", b0_a[0*16 +: 16], 16'h0FF8);
    check("R10", irq_a[0*8 +: 8], 8'h04);
    check("R9", b0_a[2*16 +: 16], 16'h0030);
    check("R8", b1_a[2*16 +: 16], 16'h0A00);
    check("R9", b1_a[3*16 +: 16], 16'h0067);
    check("R9", b0_a[6*16 +: 16], 16'h0200);

    // R3: 0x87 mid-sequence restarts as the first byte
    bus_wr(IP, 8'h87); bus_wr(IP, 8'h01); bus_wr(IP, 8'h87);
    bus_wr(IP, 8'h01); bus_wr(IP, 8'h55); bus_wr(IP, 8'h55);
    bus_rd(IP, "R3", 8'h02);
    bus_wr(DP, 8'h02);
    bus_rd(DP, "R5", 8'hFF);
    // R3: wrong byte then a late correct byte keeps it locked
    bus_wr(IP, 8'h87); bus_wr(IP, 8'h01); bus_wr(IP, 8'h55);
    bus_wr(IP, 8'h12); bus_wr(IP, 8'h55);
    bus_rd(IP, "R3", 8'hFF);

    // R2: alternate base needs 0xAA as last byte
    bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h01);
    bus_wr(16'h004E, 8'h55); bus_wr(16'h004E, 8'h55);
    bus_rd(16'h004E, "R2", 8'hFF);
    bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h01);
    bus_wr(16'h004E, 8'h55); bus_wr(16'h004E, 8'hAA);
    bus_rd(16'h004E, "R2", 8'h00);

    // R1: reset again clears everything and relocks
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check("R1", en_a, '0);
    check("R1", {b0_a, b1_a, irq_a} == '0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    bus_rd(DP, "R1", 8'hFF);
    bus_rd(16'h004E, "R1", 8'hFF);

    finish_run();
  end
endmodule